// File: doc/BRIEF.md
# Oscillator Drift Trim Prescaler

This block divides a slow oscillator, given as a per-cycle enable, down to a one-second tick. It also trims the average tick rate up or down in steps of parts per billion. A correction word holds a signed 8-bit step count and a resolution select. A phase accumulator turns that count into evenly spaced correction events. On each event the prescaler either consumes one extra oscillator count, which makes the tick early, or consumes none for that cycle, which makes the tick late.

Oscillator cycles are grouped into windows of 2^FINE_SHIFT cycles, counted from reset. In fine resolution a window carries |offset| events. In coarse resolution a window carries |offset|·2^(FINE_SHIFT−COARSE_SHIFT) events, which is |offset| events per 2^COARSE_SHIFT cycles. Software writes the correction word at any time. The new value takes effect only at the next window boundary, so every window runs under one setting.

Top module: `osc_drift_trim`

## Requirements
- R1: After reset the correction word reads 0x2000, which is zero correction. With this value `secTick` pulses once every PRESCALE oscillator enables: after enables number PRESCALE, 2·PRESCALE, and so on.
- R2: Bits 14..8 of the read value always form {0, ~S, S, S, S, S, S}, where S is bit 7. Whatever is written to bits 14..8 is ignored.
- R3: Bit 15 selects the resolution (0 fine, 1 coarse) and bits 7:0 hold a two's-complement offset from −128 to +127. Both fields read back as written.
- R4: Each oscillator enable normally consumes one prescaler count. In fine resolution with offset k, let i be the step index within the window. A correction event happens at step i exactly when floor((i+1)·|k|/2^FINE_SHIFT) > floor(i·|k|/2^FINE_SHIFT). A positive offset makes that step consume two counts.
- R5: With a negative offset, a correction event step consumes zero counts.
- R6: In coarse resolution the event rule of R4 uses |k|·2^(FINE_SHIFT−COARSE_SHIFT) in place of |k|.
- R7: A written value is copied into the active setting on the last enable of the current window, so it first affects step 0 of the next window.
- R8: Cycles with `oscEn` low consume no counts and produce no tick. `secTick` is high for one clock, in the clock after the enable whose counts carry the running total across a multiple of PRESCALE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| oscEn | input | 1 | One pulse per oscillator cycle |
| regWrEn | input | 1 | Write strobe for the correction word |
| regWrData | input | 16 | Correction word to write |
| regRdData | output | 16 | Current correction word |
| secTick | output | 1 | Corrected one-second tick pulse |

## Verification
The bench runs the block in a small configuration and tries it with the following patterns:
- **Nominal operation with a continuous enable.** This isolates the plain divider.
- **Positive and negative fine offsets.** These tell early ticks apart from late ticks.
- **Coarse offsets at both range extremes.** These separate the scaled event rate from the fine rate.
- **An enable that drops every third cycle.** This shows that idle cycles neither count nor shift the window.
- **Writes placed mid-window.** These, together with a sweep over offsets in both resolutions, distinguish boundary-aligned take-over from immediate take-over.

In every pattern, each tick position is predicted arithmetically from the running count total.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;
  typedef struct packed {
    logic adv;    // an oscillator cycle is consumed this clock
    logic skip;   // consume one extra count (tick early)
    logic stall;  // consume no count (tick late)
  } trimStrobe_t;
endpackage

// File: rtl/osc_trim_ctrl.sv
module osc_trim_ctrl
  import osc_trim_pkg::*;
#(
  parameter int FINE_SHIFT   = 20,
  parameter int COARSE_SHIFT = 18
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        oscEn,
  input  logic        regWrEn,
  input  logic [15:0] regWrData,
  output logic [15:0] regRdData,
  output trimStrobe_t strobe
);
  localparam int WIN = FINE_SHIFT;
  localparam int GAP = FINE_SHIFT - COARSE_SHIFT;

  logic           cfgMode, actMode;
  logic [7:0]     cfgOff, actOff;
  logic [WIN-1:0] winCnt, acc, inc;
  logic [7:0]     mag;
  logic [WIN:0]   sum;
  logic           carry, lastStep;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfgMode <= 1'b0;
      cfgOff  <= '0;
    end else if (regWrEn) begin
      cfgMode <= regWrData[15];
      cfgOff  <= regWrData[7:0];
    end
  end

  assign regRdData = {cfgMode, 1'b0, ~cfgOff[7], {5{cfgOff[7]}}, cfgOff};

  assign mag      = actOff[7] ? (~actOff + 8'd1) : actOff;
  assign inc      = actMode ? (WIN'(mag) << GAP) : WIN'(mag);
  assign sum      = {1'b0, acc} + {1'b0, inc};
  assign carry    = sum[WIN];
  assign lastStep = (winCnt == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      winCnt  <= '0;
      acc     <= '0;
      actMode <= 1'b0;
      actOff  <= '0;
    end else if (oscEn) begin
      winCnt <= winCnt + 1'b1;
      acc    <= sum[WIN-1:0];
      if (lastStep) begin
        actMode <= cfgMode;
        actOff  <= cfgOff;
      end
    end
  end

  assign strobe.adv   = oscEn;
  assign strobe.skip  = oscEn & carry & ~actOff[7];
  assign strobe.stall = oscEn & carry & actOff[7];

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.skip, strobe.stall}));
  p_spread_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.skip || strobe.stall) |=> !(strobe.skip || strobe.stall));
  p_cfg_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(oscEn && lastStep) |=> ($stable(actMode) && $stable(actOff)));
  p_win_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !oscEn |=> ($stable(winCnt) && $stable(acc)));
endmodule

// File: rtl/osc_trim_prescaler.sv
module osc_trim_prescaler
  import osc_trim_pkg::*;
#(
  parameter int PRESCALE = 32768
) (
  input  logic        clk,
  input  logic        rst_n,
  input  trimStrobe_t strobe,
  output logic        tick
);
  localparam int CW = $clog2(PRESCALE + 2);
  localparam logic [CW-1:0] LIMIT = CW'(PRESCALE);

  logic [CW-1:0] pscCnt, step, nxt;
  logic          wrap;

  assign step = strobe.skip ? CW'(2) : (strobe.stall ? CW'(0) : CW'(1));
  assign nxt  = pscCnt + step;
  assign wrap = (nxt >= LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pscCnt <= '0;
      tick   <= 1'b0;
    end else if (strobe.adv) begin
      pscCnt <= wrap ? (nxt - LIMIT) : nxt;
      tick   <= wrap;
    end else begin
      tick   <= 1'b0;
    end
  end

  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pscCnt < LIMIT);
  p_tick_needs_osc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(strobe.adv));
  p_stall_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.stall |=> !tick);
  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.adv |=> $stable(pscCnt));
endmodule

// File: rtl/osc_drift_trim.sv
module osc_drift_trim
  import osc_trim_pkg::*;
#(
  parameter int PRESCALE     = 32768,
  parameter int FINE_SHIFT   = 20,
  parameter int COARSE_SHIFT = 18
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        oscEn,
  input  logic        regWrEn,
  input  logic [15:0] regWrData,
  output logic [15:0] regRdData,
  output logic        secTick
);
  trimStrobe_t strobe;

  osc_trim_ctrl #(
    .FINE_SHIFT(FINE_SHIFT),
    .COARSE_SHIFT(COARSE_SHIFT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .oscEn(oscEn),
    .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .strobe(strobe)
  );

  osc_trim_prescaler #(
    .PRESCALE(PRESCALE)
  ) u_psc (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .tick(secTick)
  );
endmodule

// File: tb/tb_osc_drift_trim.sv
`timescale 1ns/1ps
module tb_osc_drift_trim;
  localparam int P  = 16;
  localparam int FS = 10;
  localparam int CS = 8;
  localparam int N  = 1 << FS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        oscEn = 1'b0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        secTick;

  int tests = 0;
  int fails = 0;
  int mTotal = 0;
  int mStep = 0;
  logic       mRegMode = 1'b0, mActMode = 1'b0;
  logic [7:0] mRegOff = '0, mActOff = '0;

  osc_drift_trim #(.PRESCALE(P), .FINE_SHIFT(FS), .COARSE_SHIFT(CS)) dut (
    .clk(clk), .rst_n(rst_n), .oscEn(oscEn), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .secTick(secTick)
  );

  always #2.5 clk = ~clk;

  function automatic logic [15:0] expRead(input logic md, input logic [7:0] off);
    return {md, 1'b0, ~off[7], {5{off[7]}}, off};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      if (fails < 20) $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic oscStep(input bit en, input bit wr, input logic [15:0] wd, input string tag);
    int sv, mag, inc, nt;
    bit ev, expTick;
    oscEn = en; regWrEn = wr; regWrData = wd;
    @(posedge clk);
    expTick = 0;
    if (en) begin
      sv  = int'($signed(mActOff));
      mag = (sv < 0) ? -sv : sv;
      inc = mActMode ? (mag << (FS - CS)) : mag;
      ev  = (((mStep + 1) * inc) / N) > ((mStep * inc) / N);
      nt  = mTotal + 1 + (ev ? ((sv < 0) ? -1 : 1) : 0);
      expTick = (nt / P) > (mTotal / P);
      mTotal = nt;
      if (mStep == N - 1) begin
        mActMode = mRegMode; mActOff = mRegOff; mStep = 0;
      end else mStep++;
    end
    if (wr) begin mRegMode = wd[15]; mRegOff = wd[7:0]; end
    #1;
    oscEn = 1'b0; regWrEn = 1'b0;
    check(tag, {15'd0, secTick}, {15'd0, expTick});
  endtask

  task automatic runN(input int n, input string tag, input int gapMod);
    for (int k = 0; k < n; k++)
      oscStep((gapMod == 0) ? 1'b1 : ((k % gapMod) != 0), 1'b0, 16'h0, tag);
  endtask

  task automatic writeWord(input logic [15:0] wd, input string tag);
    oscStep(1'b1, 1'b1, wd, tag);
    check({tag, " readback"}, regRdData, expRead(wd[15], wd[7:0]));
  endtask

  initial begin
    #(150000 * 5);
    fails++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset value and idle tick
    check("R1 reset word", regRdData, 16'h2000);
    check("R1 reset tick", {15'd0, secTick}, 16'd0);
    runN(2 * N, "R1", 0);
    // R7: mid-window write takes effect at the boundary; R2 pattern bits ignored
    runN(100, "R7", 0);
    writeWord(16'h7F05, "R2");
    check("R2 ignored bits", regRdData, 16'h2005);
    runN(2 * N, "R7", 0);
    // R5: negative fine offset
    writeWord(16'h00FD, "R5");
    check("R2 negative pattern", regRdData, 16'h1FFD);
    runN(2 * N, "R5", 0);
    // R6: coarse extremes
    writeWord(16'h807F, "R6");
    check("R3 coarse word", regRdData, 16'hA07F);
    runN(2 * N, "R6", 0);
    writeWord(16'h8080, "R6");
    check("R3 coarse neg word", regRdData, 16'h9F80);
    runN(2 * N, "R6", 0);
    // R8: gapped oscillator enable
    writeWord(16'h0064, "R8");
    runN(2 * N, "R8", 3);
    runN(40, "R8", 100000);
    // R4 / R3: sweep over offsets in both resolutions
    for (int v = -128; v < 128; v += 17) begin
      for (int md = 0; md < 2; md++) begin
        writeWord({md[0], 7'd0, 8'(v)}, "R3");
        runN(N, "R4", 0);
      end
    end
    writeWord(16'h2000, "R1");
    runN(2 * N, "R1", 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule